// File: doc/BRIEF.md
# Priority Interrupt Arbiter

This block chooses which of several interrupt requests a processor core should take next. Every request source owns a 2-bit priority code held in a small register file. The code is written through a simple write port, and a code of zero switches that source off. The sources come in two groups. The lower-numbered indices are peripheral sources and the upper indices are debug sources, and each group turns a code into a level between 0 and 3 in its own way. One selector per level picks a candidate, and the highest populated level wins.

The winner is compared against the core's 2-bit interrupt mask. When it is allowed through, the block registers three outputs: a pending flag, the new priority level and a jump vector. The vector is a programmable base plus twice the source index. These outputs stay frozen until the core acknowledges. A lowest-priority software request sits below every hardware level. Any enabled hardware request takes precedence over it. A separate registered wake line tells a sleeping core to restart its clocks whenever a qualifying request exists.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After the synchronous active-high reset, pending, level, vector and wake are all zero, every priority code is 00 and the vector base is zero.
- R2: A source whose priority code is 00 never produces a pending interrupt or a wake, whatever its request line does.
- R3: For a peripheral source (index below NUM_PERIPH), codes 01, 10 and 11 give levels 0, 1 and 2.
- R4: For a debug source (index NUM_PERIPH and above), codes 01, 10 and 11 give levels 1, 2 and 3.
- R5: Among active enabled sources, the one at the highest level is granted.
- R6: Among active enabled sources sharing the winning level, the lowest index is granted.
- R7: With the mask read as a 2-bit unsigned number M, a hardware winner at level L is taken only when L >= M. Otherwise nothing is taken.
- R8: The vector equals base + 2*index, modulo 2^VEC_W. A write to address NUM_SRC loads the base from the full data word.
- R9: The software request is taken only when no enabled hardware request is active and the mask is 00. It then reports level 0 and vector base + 2*NUM_SRC.
- R10: A take is registered one edge after the request qualifies. Pending, level and vector then hold until an edge with ack high, which clears pending. A new take can load on the edge after that.
- R11: Wake is registered each edge as "a request qualifies now". This is independent of pending and of ack.
- R12: A write to address k < NUM_SRC sets source k's code from data bits [1:0]. Writes to addresses above NUM_SRC change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_PERIPH+NUM_DEBUG | Request lines, peripherals first, then debug sources |
| swi_i | input | 1 | Lowest-priority software request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | clog2(NUM_SRC+1) | Write address: source code or vector base |
| wr_data_i | input | VEC_W | Write data |
| mask_i | input | 2 | Core interrupt mask, bit 1 high-order |
| ack_i | input | 1 | Core acknowledge of the pending interrupt |
| pend_o | output | 1 | Interrupt pending to core |
| lvl_o | output | 2 | Level of the pending interrupt |
| vec_o | output | VEC_W | Jump vector of the pending interrupt |
| wake_o | output | 1 | Request to restart core clocks |

## Verification
The hardest case to reach is a higher-priority request arriving while an earlier grant is still held. It must neither disturb the held level and vector nor be lost after the acknowledge. The bench arranges this by raising a level-0 peripheral first, then adding a level-3 debug request during the hold. It checks that the outputs stay frozen, then acknowledges and expects the level-3 grant two edges later. All source pairs are also swept over all code combinations under two masks, which exercises the priority and tie-break rules.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Convert a 2-bit priority code into a level; debug group is one step higher.
  function automatic logic [1:0] code_to_level(input logic [1:0] code, input logic dbg);
    return dbg ? code : (code - 2'd1);
  endfunction

  localparam int unsigned NUM_LEVELS = 4;

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned AW      = 4,
  parameter int unsigned VEC_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [VEC_W-1:0]         wr_data_i,
  output logic [NUM_SRC-1:0][1:0]  code_o,
  output logic [VEC_W-1:0]         base_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      base_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i < AW'(NUM_SRC))
        code_o[wr_addr_i] <= wr_data_i[1:0];
      else if (wr_addr_i == AW'(NUM_SRC))
        base_o <= wr_data_i;
    end
  end

  assert_code_write_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (wr_addr_i < AW'(NUM_SRC))) |=> (code_o[$past(wr_addr_i)] == $past(wr_data_i[1:0])));

  assert_base_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (wr_addr_i == AW'(NUM_SRC))) |=> (base_o == $past(wr_data_i)));

  assert_bad_addr_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (wr_addr_i > AW'(NUM_SRC))) |=> ($stable(code_o) && $stable(base_o)));

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  act_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  always_comb begin
    if (hit_o) begin
      assert_pick_active_R6: assert (act_i[idx_o]);
      assert_pick_lowest_R6: assert ((act_i & ((N'(1) << idx_o) - N'(1))) == '0);
    end
  end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 6,
  parameter int unsigned NUM_DEBUG  = 2,
  parameter int unsigned VEC_W      = 16,
  localparam int unsigned NUM_SRC   = NUM_PERIPH + NUM_DEBUG,
  localparam int unsigned IW        = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               swi_i,
  input  logic               wr_en_i,
  input  logic [IW-1:0]      wr_addr_i,
  input  logic [VEC_W-1:0]   wr_data_i,
  input  logic [1:0]         mask_i,
  input  logic               ack_i,
  output logic               pend_o,
  output logic [1:0]         lvl_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               wake_o
);

  logic [NUM_SRC-1:0][1:0]            code;
  logic [VEC_W-1:0]                   base;
  logic [NUM_LEVELS-1:0][NUM_SRC-1:0] act;
  logic [NUM_LEVELS-1:0]              hit;
  logic [NUM_LEVELS-1:0][IW-1:0]      idx;

  logic          win_any, take_src, take_swi, take;
  logic [1:0]    win_lvl, nxt_lvl;
  logic [IW-1:0] win_idx, nxt_idx;
  logic [VEC_W-1:0] nxt_vec;

  irq_prio_regs #(.NUM_SRC(NUM_SRC), .AW(IW), .VEC_W(VEC_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .code_o    (code),
    .base_o    (base)
  );

  // Sort each active, enabled request into the level its code selects.
  always_comb begin
    for (int l = 0; l < NUM_LEVELS; l++) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        act[l][i] = req_i[i] && (code[i] != 2'b00) &&
                    (code_to_level(code[i], (i >= NUM_PERIPH)) == l[1:0]);
      end
    end
  end

  for (genvar gl = 0; gl < NUM_LEVELS; gl++) begin : g_level
    irq_level_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
      .act_i (act[gl]),
      .hit_o (hit[gl]),
      .idx_o (idx[gl])
    );
  end

  // Highest populated level wins; ascending scan lets the top level overwrite.
  always_comb begin
    win_any = 1'b0;
    win_lvl = 2'd0;
    win_idx = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (hit[l]) begin
        win_any = 1'b1;
        win_lvl = l[1:0];
        win_idx = idx[l];
      end
    end
    take_src = win_any && (win_lvl >= mask_i);
    take_swi = !win_any && swi_i && (mask_i == 2'b00);
    take     = take_src || take_swi;
    nxt_lvl  = take_src ? win_lvl : 2'd0;
    nxt_idx  = take_src ? win_idx : IW'(NUM_SRC);
    nxt_vec  = base + VEC_W'({nxt_idx, 1'b0});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      lvl_o  <= 2'd0;
      vec_o  <= '0;
      wake_o <= 1'b0;
    end else begin
      wake_o <= take;
      if (pend_o && ack_i) begin
        pend_o <= 1'b0;
      end else if (!pend_o && take) begin
        pend_o <= 1'b1;
        lvl_o  <= nxt_lvl;
        vec_o  <= nxt_vec;
      end
    end
  end

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_o) |-> (lvl_o >= $past(mask_i)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !ack_i) |=> (pend_o && $stable(lvl_o) && $stable(vec_o)));

  assert_ack_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_o && ack_i) |=> !pend_o);

  assert_wake_with_take_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_o) |-> wake_o);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ((code == '0) && !swi_i) |=> !wake_o);

endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;

  localparam int NP = 4;
  localparam int ND = 2;
  localparam int NS = NP + ND;
  localparam int IW = $clog2(NS + 1);
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] req = '0;
  logic          swi = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_addr = '0;
  logic [VW-1:0] wr_data = '0;
  logic [1:0]    mask = 2'd0;
  logic          ack = 1'b0;
  logic          pend, wake;
  logic [1:0]    lvl;
  logic [VW-1:0] vec;

  int n_chk = 0;
  int n_bad = 0;
  int prog [NS];
  logic [VW-1:0] base_m;

  always #5 clk = ~clk;

  irq_prio_arbiter #(.NUM_PERIPH(NP), .NUM_DEBUG(ND), .VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .swi_i(swi), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .mask_i(mask), .ack_i(ack),
    .pend_o(pend), .lvl_o(lvl), .vec_o(vec), .wake_o(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Independent expectation from the requirement text.
  task automatic model(input logic [NS-1:0] rq, input logic sw, input logic [1:0] m,
                       output logic p, output logic [1:0] l, output logic [VW-1:0] v);
    int best_l, best_i;
    best_l = -1; best_i = -1;
    for (int i = 0; i < NS; i++) begin
      if (rq[i] && prog[i] != 0) begin
        int li;
        li = (i < NP) ? prog[i] - 1 : prog[i];
        if (li > best_l) begin best_l = li; best_i = i; end
      end
    end
    p = 1'b0; l = 2'd0; v = '0;
    if (best_l >= 0) begin
      if (best_l >= int'(m)) begin
        p = 1'b1; l = best_l[1:0]; v = base_m + VW'(2 * best_i);
      end
    end else if (sw && m == 2'd0) begin
      p = 1'b1; l = 2'd0; v = base_m + VW'(2 * NS);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = IW'(a); wr_data = VW'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NS) prog[a] = d & 3;
    else if (a == NS) base_m = VW'(d);
  endtask

  task automatic run_case(input string tag, input logic [NS-1:0] rq, input logic sw,
                          input logic [1:0] m);
    logic ep; logic [1:0] el; logic [VW-1:0] ev;
    @(negedge clk);
    req = '0; swi = 1'b0; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0; req = rq; swi = sw; mask = m;
    @(negedge clk);
    model(rq, sw, m, ep, el, ev);
    chk({tag, " pend"}, int'(pend), int'(ep));
    chk({tag, " R11 wake"}, int'(wake), int'(ep));
    if (ep) begin
      chk({tag, " level"}, int'(lvl), int'(el));
      chk({tag, " R8 vector"}, int'(vec), int'(ev));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    string t;
    for (int i = 0; i < NS; i++) prog[i] = 0;
    base_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pend", int'(pend), 0);
    chk("R1 wake", int'(wake), 0);
    chk("R1 level", int'(lvl), 0);
    chk("R1 vector", int'(vec), 0);
    run_case("R1 R2 codes zero", '1, 1'b0, 2'd0);

    wr(NS, 16'h1F40);

    // Every source alone, every code, every mask.
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < 4; c++) begin
        wr(s, c);
        for (int m = 0; m < 4; m++) begin
          t = (c == 0) ? "R2" : ((s < NP) ? "R3 R7" : "R4 R7");
          run_case(t, NS'(1) << s, 1'b0, 2'(m));
        end
      end
      wr(s, 0);
    end

    // All pairs, all code combinations: level ordering and index tie-break.
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        for (int ci = 1; ci < 4; ci++) begin
          for (int cj = 1; cj < 4; cj++) begin
            wr(i, ci); wr(j, cj);
            run_case("R5 R6 m0", (NS'(1) << i) | (NS'(1) << j), 1'b0, 2'd0);
            run_case("R5 R6 m2", (NS'(1) << i) | (NS'(1) << j), 1'b0, 2'd2);
          end
        end
        wr(i, 0); wr(j, 0);
      end
    end

    // Software request.
    run_case("R9 alone", '0, 1'b1, 2'd0);
    run_case("R9 masked", '0, 1'b1, 2'd1);
    wr(0, 1);
    run_case("R9 preempted", NS'(1), 1'b1, 2'd0);
    run_case("R9 blocked by masked source", NS'(1), 1'b1, 2'd1);
    run_case("R9 disabled line ignored", NS'(2), 1'b1, 2'd0);

    // Register address beyond the map.
    wr(NS + 1, 16'hFFFF);
    run_case("R12 stray write", NS'(1), 1'b0, 2'd0);
    wr(0, 16'hFFFE);
    run_case("R12 data bits 1:0", NS'(1), 1'b0, 2'd2);

    // Hold until acknowledge, then pick up the higher request.
    wr(0, 1); wr(NS - 1, 3);
    @(negedge clk);
    req = '0; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0; mask = 2'd0; req = NS'(1);
    @(negedge clk);
    chk("R10 first take", int'(pend), 1);
    chk("R10 first vector", int'(vec), int'(base_m));
    req = NS'(1) | (NS'(1) << (NS - 1));
    @(negedge clk);
    chk("R10 hold level", int'(lvl), 0);
    chk("R10 hold vector", int'(vec), int'(base_m));
    chk("R11 wake while held", int'(wake), 1);
    @(negedge clk);
    chk("R10 still held", int'(pend), 1);
    chk("R10 still level", int'(lvl), 0);
    ack = 1'b1;
    @(negedge clk);
    chk("R10 cleared by ack", int'(pend), 0);
    ack = 1'b0;
    @(negedge clk);
    chk("R10 retake pend", int'(pend), 1);
    chk("R5 retake level", int'(lvl), 3);
    chk("R8 retake vector", int'(vec), int'(base_m + VW'(2 * (NS - 1))));

    summary();
  end

endmodule